// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the eight data registers of a floating-point register stack, together with the bookkeeping that makes them behave as a stack. That bookkeeping is a 3-bit top-of-stack pointer and a 2-bit tag per physical register. The block takes one command per clock cycle: push a value, pop, free one stack-relative register, rotate the pointer forward, initialize, or check ST(0). It reports a stack overflow or underflow as a one-cycle pulse and drives the C1 condition flag. An execution pipeline uses it as its register file. All register reads name a stack-relative slot ST(i), which the block maps to the physical register (TOP + i) mod 8.

The stack is a rotating pointer over a fixed ring of registers, and each register has its own tag. Rotating the pointer, freeing a register and popping are therefore three different operations. A rotate moves only the pointer. A free touches only one tag. A pop empties the tag of ST(0) and then moves the pointer. The block also outputs the control word, which holds 16'h037F after reset or initialize, and a status word that carries the pointer and C1.

A single command decoder handles all the commands through one case statement over the command encoding. The command kinds are NOP, PUSH, POP, FREE, INCP, INIT, CHK and the reserved code. The decoder has no waiting states: every command finishes at the clock edge that samples it.

Top module: `fstk_ctrl`

## Requirements
- R1: After reset, and one cycle after an INIT command (cmd=5), the pointer is 0, every tag is 11 (tag_word = 16'hFFFF), C1 is 0, ctrl_word is 16'h037F and status_word is 16'h0000.
- R2: PUSH (cmd=1) with a non-empty-free destination first sets TOP to TOP-1 mod 8, then stores push_data in that register, which becomes the new ST(0). C1 is cleared.
- R3: A pushed value is tagged from its contents, with bits [78:64] as the exponent and [63:0] as the significand. The tag is 01 when both fields are zero. It is 10 when the exponent is all ones, the exponent is zero, or significand bit 63 is 0. In every other case the tag is 00. The tag 11 means empty.
- R4: A PUSH whose destination register (TOP-1) has a tag other than 11 is an overflow. The register and the pointer stay unchanged, C1 becomes 1, and stk_ovf is high for the next cycle.
- R5: POP (cmd=2) sets the tag of ST(0) to 11, then adds 1 to TOP mod 8, and clears C1. The data is untouched. If ST(0) was already empty, stk_unf is high for the next cycle.
- R6: FREE (cmd=3) sets the tag of ST(arg_idx) to 11. TOP, all data, all other tags and C1 stay unchanged.
- R7: INCP (cmd=4) adds 1 to TOP and wraps 7 to 0. It clears C1 and leaves all tags and data unchanged.
- R8: rd_data and rd_tag show, without a clock, the data and tag of physical register (TOP + rd_idx) mod 8.
- R9: CHK (cmd=6) pulses stk_unf in the next cycle when ST(0) is empty, and changes no state.
- R10: status_word holds TOP in bits 13:11 and C1 in bit 9, with all other bits 0. tag_word bits [2k+1:2k] hold the tag of physical register k.
- R11: NOP (cmd=0) and the reserved code (cmd=7) change no state. stk_ovf and stk_unf are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code, sampled every cycle |
| arg_idx | input | 3 | Stack-relative index for FREE |
| push_data | input | 80 | Value stored by PUSH |
| rd_idx | input | 3 | Stack-relative read index |
| rd_data | output | 80 | Data of ST(rd_idx) |
| rd_tag | output | 2 | Tag of ST(rd_idx) |
| top_ptr | output | 3 | Current top-of-stack pointer |
| tag_word | output | 16 | Tags of all physical registers |
| c1_flag | output | 1 | C1 condition flag |
| stk_ovf | output | 1 | One-cycle overflow pulse |
| stk_unf | output | 1 | One-cycle underflow pulse |
| ctrl_word | output | 16 | Control word |
| status_word | output | 16 | Status word (TOP and C1) |

## Verification
A wrong pointer moves every stack-relative read together. It shows on top_ptr and status_word right after the command that caused it, and it also shows on rd_data for any index. A lost or misplaced tag update shows on tag_word at once. It also shows later as a wrong overflow or underflow pulse, at the next PUSH into that slot or the next POP or CHK of it. This is why the random stream mixes deep fills, drains, rotations and frees, and why it checks all outputs after every command.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PUSH = 3'd1,
        CMD_POP  = 3'd2,
        CMD_FREE = 3'd3,
        CMD_INCP = 3'd4,
        CMD_INIT = 3'd5,
        CMD_CHK  = 3'd6,
        CMD_RSV  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        TAG_VALID = 2'b00,
        TAG_ZERO  = 2'b01,
        TAG_SPEC  = 2'b10,
        TAG_EMPTY = 2'b11
    } tag_e;

    localparam logic [15:0] CW_DEFAULT = 16'h037F;

endpackage

// File: rtl/fstk_tag_class.sv
module fstk_tag_class
    import fstk_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int DATA_W = EXP_W + MAN_W + 1
) (
    input  logic [DATA_W-1:0] value,
    output tag_e              tag
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = value[DATA_W-2 -: EXP_W];
    assign man_f = value[MAN_W-1:0];

    always_comb begin
        if (exp_f == '0 && man_f == '0)
            tag = TAG_ZERO;
        else if (exp_f == '1 || exp_f == '0 || !man_f[MAN_W-1])
            tag = TAG_SPEC;
        else
            tag = TAG_VALID;
    end
endmodule

// File: rtl/fstk_regfile.sv
module fstk_regfile
    import fstk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 80,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  tag_e               wr_tag,
    input  logic               clr_all,
    input  logic               clr_en,
    input  logic [PTR_W-1:0]   clr_idx,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic [1:0]         rd_tag,
    output logic [2*DEPTH-1:0] tags_o
);
    logic [DATA_W-1:0] data_arr [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        logic [DATA_W-1:0] data_q;
        tag_e              tag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q  <= TAG_EMPTY;
                data_q <= '0;
            end else if (clr_all) begin
                tag_q <= TAG_EMPTY;
            end else if (wr_en && wr_idx == PTR_W'(k)) begin
                tag_q  <= wr_tag;
                data_q <= wr_data;
            end else if (clr_en && clr_idx == PTR_W'(k)) begin
                tag_q <= TAG_EMPTY;
            end
        end

        assign data_arr[k]       = data_q;
        assign tags_o[2*k +: 2]  = tag_q;
    end

    assign rd_data = data_arr[rd_idx];
    assign rd_tag  = tags_o[2*rd_idx +: 2];

    assert_init_tags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (tags_o == '1));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> (data_arr[$past(wr_idx)] == $past(wr_data)));

    assert_no_write_on_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));
endmodule

// File: rtl/fstk_seq.sv
module fstk_seq
    import fstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_e               cmd,
    input  logic [PTR_W-1:0]   arg_idx,
    input  logic [2*DEPTH-1:0] tags,
    output logic [PTR_W-1:0]   top_q,
    output logic               c1_q,
    output logic               ovf_q,
    output logic               unf_q,
    output logic               wr_en,
    output logic [PTR_W-1:0]   wr_idx,
    output logic               clr_all,
    output logic               clr_en,
    output logic [PTR_W-1:0]   clr_idx,
    output logic [15:0]        cw_q,
    output logic [15:0]        sw
);
    logic [PTR_W-1:0] top_n, dest, top_inc;
    logic             c1_n, ovf_n, unf_n, cw_load;
    logic             st0_empty, dest_empty;

    assign dest       = top_q - PTR_W'(1);
    assign top_inc    = top_q + PTR_W'(1);
    assign st0_empty  = (tags[2*top_q +: 2] == TAG_EMPTY);
    assign dest_empty = (tags[2*dest  +: 2] == TAG_EMPTY);

    // command decode: next pointer, flag and register-file strobes
    always_comb begin
        top_n   = top_q;
        c1_n    = c1_q;
        ovf_n   = 1'b0;
        unf_n   = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = dest;
        clr_all = 1'b0;
        clr_en  = 1'b0;
        clr_idx = top_q;
        cw_load = 1'b0;
        unique case (cmd)
            CMD_PUSH: begin
                if (!dest_empty) begin
                    ovf_n = 1'b1;
                    c1_n  = 1'b1;
                end else begin
                    wr_en = 1'b1;
                    top_n = dest;
                    c1_n  = 1'b0;
                end
            end
            CMD_POP: begin
                unf_n  = st0_empty;
                clr_en = 1'b1;
                top_n  = top_inc;
                c1_n   = 1'b0;
            end
            CMD_FREE: begin
                clr_en  = 1'b1;
                clr_idx = top_q + arg_idx;
            end
            CMD_INCP: begin
                top_n = top_inc;
                c1_n  = 1'b0;
            end
            CMD_INIT: begin
                clr_all = 1'b1;
                top_n   = '0;
                c1_n    = 1'b0;
                cw_load = 1'b1;
            end
            CMD_CHK: begin
                unf_n = st0_empty;
            end
            CMD_NOP, CMD_RSV: begin
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
            c1_q  <= 1'b0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            cw_q  <= CW_DEFAULT;
        end else begin
            top_q <= top_n;
            c1_q  <= c1_n;
            ovf_q <= ovf_n;
            unf_q <= unf_n;
            if (cw_load) cw_q <= CW_DEFAULT;
        end
    end

    // status word: pointer in 13:11, C1 in bit 9
    always_comb begin
        sw           = '0;
        sw[11 +: PTR_W] = top_q;
        sw[9]        = c1_q;
    end

    assert_init_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_INIT) |=> (top_q == '0 && !c1_q && cw_q == CW_DEFAULT));

    assert_incp_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_INCP) |=> (top_q == PTR_W'($past(top_q) + PTR_W'(1)) && !c1_q));

    assert_ovf_c1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> c1_q);

    assert_ovf_keeps_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PUSH && !dest_empty) |=> $stable(top_q));

    assert_free_keeps_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FREE) |=> ($stable(top_q) && $stable(c1_q)));

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q));
endmodule

// File: rtl/fstk_ctrl.sv
module fstk_ctrl
    import fstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int DATA_W = EXP_W + MAN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cmd,
    input  logic [PTR_W-1:0]   arg_idx,
    input  logic [DATA_W-1:0]  push_data,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic [1:0]         rd_tag,
    output logic [PTR_W-1:0]   top_ptr,
    output logic [2*DEPTH-1:0] tag_word,
    output logic               c1_flag,
    output logic               stk_ovf,
    output logic               stk_unf,
    output logic [15:0]        ctrl_word,
    output logic [15:0]        status_word
);
    tag_e             push_tag;
    logic             wr_en, clr_all, clr_en;
    logic [PTR_W-1:0] wr_idx, clr_idx, rd_phys;

    fstk_tag_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
        .value (push_data),
        .tag   (push_tag)
    );

    fstk_seq #(.DEPTH(DEPTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd_e'(cmd)),
        .arg_idx (arg_idx),
        .tags    (tag_word),
        .top_q   (top_ptr),
        .c1_q    (c1_flag),
        .ovf_q   (stk_ovf),
        .unf_q   (stk_unf),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .clr_all (clr_all),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .cw_q    (ctrl_word),
        .sw      (status_word)
    );

    assign rd_phys = top_ptr + rd_idx;

    fstk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .wr_tag  (push_tag),
        .clr_all (clr_all),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .rd_idx  (rd_phys),
        .rd_data (rd_data),
        .rd_tag  (rd_tag),
        .tags_o  (tag_word)
    );

    assert_pop_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2) |=> (((tag_word >> (2*$past(top_ptr))) & 16'd3) == 16'd3));

    assert_nop_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd0 || cmd == 3'd7) |=> ($stable(tag_word) && $stable(top_ptr) && !stk_ovf && !stk_unf));
endmodule

// File: tb/tb_fstk_ctrl.sv
module tb_fstk_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [2:0]  arg_idx = 3'd0;
    logic [79:0] push_data = '0;
    logic [2:0]  rd_idx = 3'd0;
    logic [79:0] rd_data;
    logic [1:0]  rd_tag;
    logic [2:0]  top_ptr;
    logic [15:0] tag_word;
    logic        c1_flag, stk_ovf, stk_unf;
    logic [15:0] ctrl_word, status_word;

    int n_chk = 0;
    int n_err = 0;

    logic [79:0] m_data [8];
    logic [1:0]  m_tag  [8];
    logic [2:0]  m_top;
    logic        m_c1, m_ovf, m_unf;

    always #(CLK_PERIOD/2) clk = ~clk;

    fstk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .arg_idx(arg_idx),
        .push_data(push_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_tag(rd_tag), .top_ptr(top_ptr), .tag_word(tag_word),
        .c1_flag(c1_flag), .stk_ovf(stk_ovf), .stk_unf(stk_unf),
        .ctrl_word(ctrl_word), .status_word(status_word)
    );

    function automatic logic [1:0] classify(logic [79:0] v);
        logic [14:0] e = v[78:64];
        logic [63:0] m = v[63:0];
        if (e == 0 && m == 0) return 2'b01;
        if (e == 15'h7FFF || e == 0 || !m[63]) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [79:0] make_val(int kind);
        logic [79:0] v;
        v = {$urandom, $urandom, $urandom};
        case (kind)
            0: v[78:0] = '0;
            1: begin v[78:64] = 15'($urandom_range(1, 32'h7FFE)); v[63] = 1'b1; end
            2: v[78:64] = 15'h7FFF;
            3: begin v[78:64] = '0; v[63] = 1'b0; v[0] = 1'b1; end
            default: begin v[78:64] = 15'h3FFF; v[63] = 1'b0; end
        endcase
        return v;
    endfunction

    function automatic logic [15:0] model_tags();
        logic [15:0] t;
        for (int k = 0; k < 8; k++) t[2*k +: 2] = m_tag[k];
        return t;
    endfunction

    task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin m_tag[k] = 2'b11; m_data[k] = '0; end
        m_top = 0; m_c1 = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic check_all(string req);
        logic [2:0] p;
        logic [15:0] sw;
        p  = m_top + rd_idx;
        sw = '0; sw[13:11] = m_top; sw[9] = m_c1;
        chk({req, " top"}, 80'(top_ptr), 80'(m_top));
        chk({req, " tags R3"}, 80'(tag_word), 80'(model_tags()));
        chk({req, " c1 R4"}, 80'(c1_flag), 80'(m_c1));
        chk({req, " ovf R4"}, 80'(stk_ovf), 80'(m_ovf));
        chk({req, " unf R9"}, 80'(stk_unf), 80'(m_unf));
        chk({req, " status R10"}, 80'(status_word), 80'(sw));
        chk({req, " ctrl R1"}, 80'(ctrl_word), 80'(16'h037F));
        chk({req, " rd_tag R8"}, 80'(rd_tag), 80'(m_tag[p]));
        chk({req, " rd_data R8"}, rd_data, m_data[p]);
    endtask

    // drive at falling edge, apply on rising edge, check at next falling edge
    task automatic op(logic [2:0] c, logic [2:0] a, logic [79:0] d, logic [2:0] r);
        logic [2:0] dst;
        string req;
        cmd = c; arg_idx = a; push_data = d; rd_idx = r;
        m_ovf = 0; m_unf = 0;
        case (c)
            3'd1: begin
                req = "R2";
                dst = m_top - 3'd1;
                if (m_tag[dst] != 2'b11) begin m_ovf = 1; m_c1 = 1; end
                else begin
                    m_top = dst; m_data[dst] = d; m_tag[dst] = classify(d); m_c1 = 0;
                end
            end
            3'd2: begin
                req = "R5";
                m_unf = (m_tag[m_top] == 2'b11);
                m_tag[m_top] = 2'b11; m_top = m_top + 3'd1; m_c1 = 0;
            end
            3'd3: begin req = "R6"; m_tag[3'(m_top + a)] = 2'b11; end
            3'd4: begin req = "R7"; m_top = m_top + 3'd1; m_c1 = 0; end
            3'd5: begin
                req = "R1";
                for (int k = 0; k < 8; k++) m_tag[k] = 2'b11;
                m_top = 0; m_c1 = 0;
            end
            3'd6: begin req = "R9"; m_unf = (m_tag[m_top] == 2'b11); end
            default: req = "R11";
        endcase
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: fill all eight slots with every value class
        for (int i = 0; i < 8; i++) op(3'd1, 0, make_val(i % 5), 3'(i));
        // R4: ninth push overflows, pointer and data untouched
        op(3'd1, 0, make_val(1), 3'd0);
        op(3'd1, 0, make_val(0), 3'd7);
        // R11: NOP and reserved code after overflow
        op(3'd0, 0, make_val(1), 3'd2);
        op(3'd7, 0, make_val(1), 3'd3);
        // R6: free ST(3), data stays readable
        op(3'd3, 3'd3, '0, 3'd3);
        // R7: rotate eight times returns pointer
        for (int i = 0; i < 8; i++) op(3'd4, 0, '0, 3'(i));
        // R5: pops, including the freed slot (underflow)
        for (int i = 0; i < 5; i++) op(3'd2, 0, '0, 3'd0);
        // R1: initialize, then underflow by CHK and POP
        op(3'd5, 0, '0, 3'd0);
        op(3'd6, 0, '0, 3'd0);
        op(3'd2, 0, '0, 3'd1);
        op(3'd5, 0, '0, 3'd0);

        // constrained random stream
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 19);
            logic [2:0] c;
            if (r < 8) c = 3'd1;
            else if (r < 11 || r == 18) c = 3'd2;
            else if (r < 13) c = 3'd3;
            else if (r < 15) c = 3'd4;
            else if (r == 15) c = 3'd6;
            else if (r == 16) c = 3'd0;
            else if (r == 17) c = 3'd7;
            else c = 3'd5;
            op(c, 3'($urandom_range(0, 7)), make_val($urandom_range(0, 4)),
               3'($urandom_range(0, 7)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule